// File: doc/BRIEF.md
# Precise Exception Controller

This block is the control path that keeps exceptions precise in a five-stage in-order pipeline. Every cycle it looks at the exception flags of the fetch, decode, execute and memory stages, plus an external interrupt request. It picks the oldest excepting instruction. It then turns that instruction and every younger one into a bubble by raising their squash strobes, so they write neither registers nor memory. The instruction in write-back is older than any of them, so it is never touched and completes normally. An interrupt is taken between instructions: it is handled as a fault on the instruction currently in the memory stage.

In the cycle after an exception is taken, fetch is redirected to a fixed handler vector. The controller keeps the restart state until the next exception is taken: the faulting instruction's PC, the target of the branch that owns it, a cause code and a delay-slot flag. A return-from-exception pulse replays fetch from the saved PC. If the faulting instruction sat in a branch delay slot, the replay then continues at the saved branch target on the following cycle. After that, sequential fetch carries on in the datapath.

Top module: `pexc_top`

## Requirements
- R1: When the memory stage (array index 3) flags an exception and the controller is not masked, all four squash bits are high in that same cycle. Squash bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory.
- R2: When several stages flag exceptions together, the highest-indexed (oldest) stage is the faulting one. Squash is high for that stage and every lower index, and low for every higher index.
- R3: After reset, squash is zero, no redirect is driven, and all saved fields read zero. With no exception flags and no interrupt, squash stays zero.
- R4: In the cycle after an exception is taken, redirValid is high and redirPc equals HANDLER_VEC (default 32'h0000_0080).
- R5: The cycle after an exception is taken, epc1 holds the faulting stage's PC, epc2 holds that stage's branch target input, epcInSlot holds that stage's slot flag, and epcCause holds that stage's cause code.
- R6: The saved fields change only when an exception is taken. A return pulse and the replay leave them unchanged.
- R7: A return pulse that arrives after the handler redirect drives redirValid with redirPc = epc1 on the next cycle. When epcInSlot is 0, no further redirect follows.
- R8: When epcInSlot is 1, the epc1 redirect is followed on the very next cycle by a redirect to epc2, and then by no redirect.
- R9: An interrupt request is taken as a fault of the memory-stage instruction and squashes all four stages. Its cause code is IRQ_CAUSE (default all ones, 5'h1F) unless the memory stage flags its own exception, in which case that stage's cause is saved.
- R10: In the handler-redirect cycle, exception flags and interrupts are ignored: squash stays zero and the saved fields are not updated.
- R11: A return pulse is ignored when no exception has been taken since the last replay, when it arrives in the handler-redirect cycle, and when an exception is taken in the same cycle. In these cases no replay redirect follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stageExc | input | 4 | Exception flag per stage (0 fetch .. 3 memory) |
| stageCause | input | 4x5 | Cause code per stage |
| stagePc | input | 4x32 | PC of the instruction in each stage |
| stageTgt | input | 4x32 | Target of the branch owning each stage's instruction |
| stageSlot | input | 4 | Instruction in stage sits in a branch delay slot |
| extIrq | input | 1 | External interrupt request |
| eret | input | 1 | Return-from-exception pulse |
| squash | output | 4 | Per-stage bubble strobe (write enables cleared) |
| redirValid | output | 1 | Fetch redirect this cycle |
| redirPc | output | 32 | Fetch redirect address |
| epc1 | output | 32 | Saved restart PC |
| epc2 | output | 32 | Saved branch target for delay-slot restart |
| epcCause | output | 5 | Saved cause code |
| epcInSlot | output | 1 | Saved delay-slot indicator |

## Verification
Several properties are checked on every cycle by assertions. The squash mask always covers the faulting stage and every younger one, with no gaps. A memory-stage fault or an interrupt squashes the whole pipe. The cycle after a squash is both masked and pointed at the handler vector. The saved fields hold steady whenever nothing is captured. A second replay address appears only right after the first. Other behaviours can only be shown by the bench's scenarios, because they need to know which stage's PC, target and cause should have been kept. These are: the exact saved values, the choice of interrupt cause against a memory-stage cause, return pulses that must be dropped, and the ordering of the two replay addresses when a delay slot faults.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
  localparam int PIPE_STAGES = 4;
  localparam int STG_W = $clog2(PIPE_STAGES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_VECTOR, ST_HANDLER, ST_REPLAY1, ST_REPLAY2
  } ctlStateT;

  typedef enum logic [1:0] {
    SEL_NONE, SEL_HANDLER, SEL_EPC1, SEL_EPC2
  } redirSelT;

  typedef struct packed {
    logic capture;
    logic [STG_W-1:0] stage;
    logic useIrq;
    redirSelT sel;
  } ctlStrobeT;
endpackage

// File: rtl/pexc_ctl.sv
module pexc_ctl
  import pexc_pkg::*;
#(
  parameter int NSTG = PIPE_STAGES
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NSTG-1:0] stageExc,
  input  logic extIrq,
  input  logic eret,
  input  logic savedSlot,
  output logic [NSTG-1:0] squash,
  output ctlStrobeT strobe
);
  localparam int MEMI = NSTG - 1;

  ctlStateT state, stateNext;
  logic [NSTG-1:0] effExc;
  logic masked, take;
  logic [STG_W-1:0] faultIdx;

  // interrupt attaches to the instruction in the memory stage
  always_comb begin
    effExc = stageExc;
    effExc[MEMI] = stageExc[MEMI] | extIrq;
  end

  assign masked = (state == ST_VECTOR);
  assign take = !masked && (|effExc);

  // oldest (highest index) flagged stage wins
  always_comb begin
    faultIdx = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (effExc[i]) faultIdx = STG_W'(i);
    end
  end

  // a stage is squashed when it or any older stage faults
  for (genvar g = 0; g < NSTG; g++) begin : gSquash
    assign squash[g] = take & (|effExc[NSTG-1:g]);
  end

  always_comb begin
    stateNext = state;
    if (take) begin
      stateNext = ST_VECTOR;
    end else begin
      unique case (state)
        ST_VECTOR:  stateNext = ST_HANDLER;
        ST_HANDLER: if (eret) stateNext = ST_REPLAY1;
        ST_REPLAY1: stateNext = savedSlot ? ST_REPLAY2 : ST_IDLE;
        ST_REPLAY2: stateNext = ST_IDLE;
        default:    stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.capture = take;
    strobe.stage = faultIdx;
    strobe.useIrq = extIrq & ~stageExc[MEMI];
    unique case (state)
      ST_VECTOR:  strobe.sel = SEL_HANDLER;
      ST_REPLAY1: strobe.sel = SEL_EPC1;
      ST_REPLAY2: strobe.sel = SEL_EPC2;
      default:    strobe.sel = SEL_NONE;
    endcase
  end

  AST_MEM_SQUASH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_VECTOR && (stageExc[MEMI] || extIrq)) |-> (&squash)); // R1

  AST_SQUASH_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (squash != '0) |-> (squash[0] && ((squash & (squash + 1'b1)) == '0))); // R2

  AST_MASK_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (squash != '0) |=> (squash == '0)); // R10
endmodule

// File: rtl/pexc_dp.sv
module pexc_dp
  import pexc_pkg::*;
#(
  parameter int NSTG = PIPE_STAGES,
  parameter int XLEN = 32,
  parameter int CW = 5,
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h0000_0080,
  parameter logic [CW-1:0] IRQ_CAUSE = '1
) (
  input  logic clk,
  input  logic rstN,
  input  ctlStrobeT strobe,
  input  logic [NSTG-1:0][XLEN-1:0] stagePc,
  input  logic [NSTG-1:0][XLEN-1:0] stageTgt,
  input  logic [NSTG-1:0][CW-1:0] stageCause,
  input  logic [NSTG-1:0] stageSlot,
  output logic [XLEN-1:0] epc1,
  output logic [XLEN-1:0] epc2,
  output logic [CW-1:0] epcCause,
  output logic epcInSlot,
  output logic redirValid,
  output logic [XLEN-1:0] redirPc
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      epc1 <= '0;
      epc2 <= '0;
      epcCause <= '0;
      epcInSlot <= 1'b0;
    end else if (strobe.capture) begin
      epc1 <= stagePc[strobe.stage];
      epc2 <= stageTgt[strobe.stage];
      epcCause <= strobe.useIrq ? IRQ_CAUSE : stageCause[strobe.stage];
      epcInSlot <= stageSlot[strobe.stage];
    end
  end

  always_comb begin
    redirValid = (strobe.sel != SEL_NONE);
    unique case (strobe.sel)
      SEL_HANDLER: redirPc = HANDLER_VEC;
      SEL_EPC1:    redirPc = epc1;
      SEL_EPC2:    redirPc = epc2;
      default:     redirPc = '0;
    endcase
  end

  AST_VECTOR_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (redirValid && redirPc == HANDLER_VEC)); // R4

  AST_HOLD_SAVED: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(epc1) && $stable(epc2) && $stable(epcCause) && $stable(epcInSlot))); // R6

  AST_REPLAY_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SEL_EPC2) |-> ($past(strobe.sel) == SEL_EPC1 && epcInSlot)); // R8

  AST_REPLAY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SEL_EPC1) |-> ($past(strobe.sel) == SEL_NONE)); // R7
endmodule

// File: rtl/pexc_top.sv
module pexc_top
  import pexc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW = 5,
  parameter logic [XLEN-1:0] HANDLER_VEC = 32'h0000_0080,
  parameter logic [CW-1:0] IRQ_CAUSE = '1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [PIPE_STAGES-1:0] stageExc,
  input  logic [PIPE_STAGES-1:0][CW-1:0] stageCause,
  input  logic [PIPE_STAGES-1:0][XLEN-1:0] stagePc,
  input  logic [PIPE_STAGES-1:0][XLEN-1:0] stageTgt,
  input  logic [PIPE_STAGES-1:0] stageSlot,
  input  logic extIrq,
  input  logic eret,
  output logic [PIPE_STAGES-1:0] squash,
  output logic redirValid,
  output logic [XLEN-1:0] redirPc,
  output logic [XLEN-1:0] epc1,
  output logic [XLEN-1:0] epc2,
  output logic [CW-1:0] epcCause,
  output logic epcInSlot
);
  ctlStrobeT strobe;

  pexc_ctl #(.NSTG(PIPE_STAGES)) uCtl (
    .clk(clk), .rstN(rstN), .stageExc(stageExc), .extIrq(extIrq),
    .eret(eret), .savedSlot(epcInSlot), .squash(squash), .strobe(strobe)
  );

  pexc_dp #(
    .NSTG(PIPE_STAGES), .XLEN(XLEN), .CW(CW),
    .HANDLER_VEC(HANDLER_VEC), .IRQ_CAUSE(IRQ_CAUSE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stagePc(stagePc),
    .stageTgt(stageTgt), .stageCause(stageCause), .stageSlot(stageSlot),
    .epc1(epc1), .epc2(epc2), .epcCause(epcCause), .epcInSlot(epcInSlot),
    .redirValid(redirValid), .redirPc(redirPc)
  );
endmodule

// File: tb/sim_pexc_top.sv
`timescale 1ns/1ps
module sim_pexc_top;
  localparam logic [31:0] HVEC = 32'h0000_0080;
  localparam logic [4:0] IRQC = 5'h1F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] stageExc = '0;
  logic [3:0][4:0] stageCause = '0;
  logic [3:0][31:0] stagePc = '0;
  logic [3:0][31:0] stageTgt = '0;
  logic [3:0] stageSlot = '0;
  logic extIrq = 1'b0;
  logic eret = 1'b0;
  logic [3:0] squash;
  logic redirValid;
  logic [31:0] redirPc;
  logic [31:0] epc1, epc2;
  logic [4:0] epcCause;
  logic epcInSlot;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // model: 0 idle, 1 vector, 2 handler, 3 replay1, 4 replay2
  int mState = 0;
  logic [31:0] mEpc1 = '0, mEpc2 = '0;
  logic [4:0] mCause = '0;
  logic mSlot = 1'b0;

  always #4 clk = ~clk;

  pexc_top u0 (
    .clk(clk), .rstN(rstN), .stageExc(stageExc), .stageCause(stageCause),
    .stagePc(stagePc), .stageTgt(stageTgt), .stageSlot(stageSlot),
    .extIrq(extIrq), .eret(eret), .squash(squash), .redirValid(redirValid),
    .redirPc(redirPc), .epc1(epc1), .epc2(epc2), .epcCause(epcCause),
    .epcInSlot(epcInSlot)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] effFlags(input logic [3:0] e, input logic irq);
    return e | {irq, 3'b000};
  endfunction

  function automatic int oldest(input logic [3:0] f);
    int k = -1;
    for (int i = 0; i < 4; i++) if (f[i]) k = i;
    return k;
  endfunction

  function automatic logic [3:0] expSquash(input logic [3:0] e, input logic irq, input int st);
    int k = oldest(effFlags(e, irq));
    if (st == 1 || k < 0) return 4'b0000;
    return 4'((5'd1 << (k + 1)) - 1);
  endfunction

  function automatic logic [31:0] expRedir(input int st);
    case (st)
      1: return HVEC;
      3: return mEpc1;
      4: return mEpc2;
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic [3:0] e, input logic irq, input logic er, input logic [3:0] sl);
    logic [3:0] f;
    int k;
    string sqTag, rdTag;
    @(negedge clk);
    stageExc = e; extIrq = irq; eret = er; stageSlot = sl;
    for (int i = 0; i < 4; i++) begin
      stagePc[i] = $urandom & 32'hFFFF_FFFC;
      stageTgt[i] = $urandom & 32'hFFFF_FFFC;
      stageCause[i] = 5'($urandom_range(1, 30));
    end
    #1;
    f = effFlags(e, irq);
    k = oldest(f);
    if (mState == 1 && k >= 0) sqTag = "R10";
    else if (k < 0) sqTag = "R3";
    else if (irq && !e[3]) sqTag = "R9";
    else if (e[3]) sqTag = "R1";
    else sqTag = "R2";
    chk(sqTag, 64'(squash), 64'(expSquash(e, irq, mState)));
    case (mState)
      1: rdTag = "R4";
      3: rdTag = "R7";
      4: rdTag = "R8";
      default: rdTag = "R11";
    endcase
    chk(rdTag, 64'(redirValid), 64'(mState == 1 || mState >= 3));
    chk(rdTag, 64'(redirPc), 64'(expRedir(mState)));
    chk((mState == 1) ? "R5" : "R6", {epc1, epc2}, {mEpc1, mEpc2});
    chk((mState == 1) ? "R5" : "R6", 64'({epcCause, epcInSlot}), 64'({mCause, mSlot}));
    // advance model
    if (mState != 1 && k >= 0) begin
      mEpc1 = stagePc[k];
      mEpc2 = stageTgt[k];
      mSlot = sl[k];
      mCause = (k == 3 && irq && !e[3]) ? IRQC : stageCause[k];
      mState = 1;
    end else begin
      case (mState)
        1: mState = 2;
        2: if (er) mState = 3;
        3: mState = mSlot ? 4 : 0;
        4: mState = 0;
        default: mState = 0;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'b0000, 1'b0, 1'b0, 4'b0000);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", wd);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] e, sl;
    void'($urandom(32'd1418));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R3: reset state
    #1;
    chk("R3", 64'({squash, redirValid}), 64'h0);
    chk("R3", {epc1, epc2}, 64'h0);
    chk("R3", 64'({epcCause, epcInSlot}), 64'h0);
    idle(2);
    // R11: return pulse with nothing outstanding
    step(4'b0000, 1'b0, 1'b1, 4'b0000);
    idle(2);
    // R1: memory fault, no slot; then return and single replay (R7)
    step(4'b1000, 1'b0, 1'b0, 4'b0000);
    step(4'b1111, 1'b1, 1'b1, 4'b0000); // R10 masked, R11 eret in vector cycle
    idle(2);
    step(4'b0000, 1'b0, 1'b1, 4'b0000);
    idle(3);
    // R2: execute and decode both flag, execute wins
    step(4'b0110, 1'b0, 1'b0, 4'b0000);
    idle(1);
    // R8: delay-slot fault in memory stage, two-address replay
    step(4'b1000, 1'b0, 1'b0, 4'b1000);
    idle(1);
    step(4'b0000, 1'b0, 1'b1, 4'b0000);
    idle(4);
    // R9: interrupt alone, then interrupt with memory fault
    step(4'b0001, 1'b1, 1'b0, 4'b0000);
    idle(1);
    step(4'b1000, 1'b1, 1'b0, 4'b0000);
    idle(1);
    // R11: return pulse coinciding with a new exception
    step(4'b0100, 1'b0, 1'b1, 4'b0100);
    idle(3);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      e = '0;
      for (int i = 0; i < 4; i++) e[i] = ($urandom_range(0, 9) == 0);
      sl = 4'($urandom);
      step(e, $urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0, sl);
    end
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule